// File: doc/BRIEF.md
# Recirculating Serial Word Store

This block models a memory line in which every bit travels in a closed loop. The line holds a fixed number of words. One bit reaches the access point on each clock and is fed back into the far end of the loop. Two free-running counters, one for the bit within a word and one for the word, always name the bit that is at the access point. A word can be read or changed only while it passes that point. Access therefore depends on time rather than on an address decoder.

A client issues a transfer with a mode, a starting word position and a word count. The block waits until the chosen word comes round, then streams the requested number of consecutive words past the access point, one bit per clock, least significant bit first. A count can be one word more than a full revolution, so the start word is visited twice.

In write mode the serial input bit replaces each emerging bit. In read mode the emerging bits are shown on the output and the contents are left alone. In summing mode every emerging word is added, bit-serially, into a single-length accumulator that is seeded when the request is accepted.

Top module: `rsl_word_store`

## Requirements
- R1: While reset is held and right after it, the line holds all zeros, both position counters read 0, busy and done are low, and the accumulator reads 0.
- R2: `bit_pos` advances by one on every clock and wraps from 31 to 0. `word_pos` advances by one (wrapping 31 to 0) on each clock where `bit_pos` wraps. A full revolution therefore takes 1024 clocks.
- R3: An accepted transfer starts in the first cycle after the request cycle in which `word_pos` equals the requested start and `bit_pos` is 0. `xfer_act` is then high for exactly count × 32 consecutive cycles. A request made in the very cycle that the start word's bit 0 is present waits a full revolution (1024 cycles).
- R4: On every clock, `xfer_bit` presents bit `bit_pos` of word `word_pos` as stored, so each word appears least significant bit first.
- R5: In write mode (`req_mode` = 1), during each active cycle the value on `wr_bit` replaces the emerging bit. It emerges again one revolution later.
- R6: Any bit not being written goes back into the line unchanged. `wr_bit` has no effect outside active write cycles.
- R7: `busy` rises in the cycle after an accepted request and stays high through the last active bit. `done` is a one-cycle pulse in the following cycle, during which `busy` is low.
- R8: In summing mode (`req_mode` = 2), the accumulator is loaded from `acc_seed` on acceptance. Each transferred word is added modulo 2^32, with no carry passing from one word into the next. The result holds after the transfer.
- R9: Legal counts are 1 to 33. A count of 33 transfers the start word twice. A request with count 0 or above 33 is ignored and `busy` stays low.
- R10: A request made while `busy` is high is ignored. It changes neither the line nor the accumulator, and no extra transfer follows.
- R11: Read mode (`req_mode` = 0 or 3) leaves the line contents and the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Transfer request, sampled when idle |
| req_mode | input | 2 | 0/3 read, 1 write, 2 sum |
| req_start | input | 5 | Word position at which the transfer begins |
| req_count | input | 6 | Number of words, 1 to 33 |
| acc_seed | input | 32 | Accumulator start value for a summing transfer |
| wr_bit | input | 1 | Serial write data |
| busy | output | 1 | Transfer pending or in progress |
| done | output | 1 | One-cycle pulse after the last bit |
| xfer_act | output | 1 | Current bit belongs to the transfer |
| xfer_bit | output | 1 | Bit now at the access point |
| word_pos | output | 5 | Word now at the access point |
| bit_pos | output | 5 | Bit index now at the access point |
| acc_sum | output | 32 | Accumulator value |

## Verification
The bench keeps a behavioural model of the 32 words and compares every output on every clock, while `wr_bit` toggles constantly so that a leaky write path would corrupt words outside the transfer. It aims at wrap-around transfers that cross word 31 to word 0, 33-word transfers that revisit the start word, and a request issued exactly as the start word passes. A design that started one word early or late, failed to stop at the count, or let the serial carry leak between words would show wrong bits or a wrong sum. Rejected counts and requests made while busy are checked to leave `busy`, the contents and the accumulator untouched.

// File: rtl/rsl_pkg.sv
package rsl_pkg;

    typedef enum logic [1:0] {
        XM_READ     = 2'd0,
        XM_WRITE    = 2'd1,
        XM_SUM      = 2'd2,
        XM_READ_ALT = 2'd3
    } xmode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } xstate_e;

endpackage

// File: rtl/rsl_line.sv
module rsl_line #(
    parameter int WORD_BITS = 32,
    parameter int WORDS     = 32,
    localparam int BW = $clog2(WORD_BITS),
    localparam int WW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bit,
    output logic          out_bit,
    output logic [BW-1:0] bit_pos,
    output logic [WW-1:0] word_pos,
    output logic          word_end
);
    localparam int LINE_BITS = WORD_BITS * WORDS;

    typedef struct packed {
        logic [LINE_BITS-1:0] line;
        logic [BW-1:0]        bpos;
        logic [WW-1:0]        wpos;
    } line_s;

    line_s line_d, line_q;
    logic  end_c;

    always_comb begin
        line_d      = line_q;
        line_d.line = {(wr_en ? wr_bit : line_q.line[0]), line_q.line[LINE_BITS-1:1]};
        end_c       = (line_q.bpos == BW'(WORD_BITS - 1));
        line_d.bpos = end_c ? '0 : line_q.bpos + 1'b1;
        if (end_c) begin
            line_d.wpos = (line_q.wpos == WW'(WORDS - 1)) ? '0 : line_q.wpos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign out_bit  = line_q.line[0];
    assign bit_pos  = line_q.bpos;
    assign word_pos = line_q.wpos;
    assign word_end = end_c;

    a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_pos != BW'(WORD_BITS - 1)) |=> (bit_pos == $past(bit_pos) + 1'b1));

    a_r2_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_pos == BW'(WORD_BITS - 1) && word_pos != WW'(WORDS - 1))
        |=> (bit_pos == '0) && (word_pos == $past(word_pos) + 1'b1));

    a_r6_recirculate: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (line_q.line[LINE_BITS-1] == $past(out_bit)));

    a_r5_write_enters: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (line_q.line[LINE_BITS-1] == $past(wr_bit)));

endmodule

// File: rtl/rsl_ctrl.sv
module rsl_ctrl
    import rsl_pkg::*;
#(
    parameter int WORD_BITS = 32,
    parameter int WORDS     = 32,
    localparam int MAX_COUNT = WORDS + 1,
    localparam int BW = $clog2(WORD_BITS),
    localparam int WW = $clog2(WORDS),
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [1:0]    req_mode,
    input  logic [WW-1:0] req_start,
    input  logic [CW-1:0] req_count,
    input  logic [BW-1:0] bit_pos,
    input  logic [WW-1:0] word_pos,
    input  logic          word_end,
    output logic          busy,
    output logic          done,
    output logic          act,
    output xmode_e        mode,
    output logic          load_acc
);
    typedef struct packed {
        xstate_e       st;
        logic [WW-1:0] start;
        logic [CW-1:0] left;
        xmode_e        mode;
        logic          done;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;
    logic  hit, last, count_ok, accept;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        count_ok   = (req_count != '0) && (req_count <= CW'(MAX_COUNT));
        accept     = 1'b0;
        hit        = (ctl_q.st == ST_WAIT) && (word_pos == ctl_q.start) && (bit_pos == '0);
        act        = (ctl_q.st == ST_RUN) || hit;
        last       = act && word_end && (ctl_q.left == CW'(1));

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req && count_ok) begin
                    accept      = 1'b1;
                    ctl_d.st    = ST_WAIT;
                    ctl_d.start = req_start;
                    ctl_d.left  = req_count;
                    ctl_d.mode  = xmode_e'(req_mode);
                end
            end
            ST_WAIT: begin
                if (hit) ctl_d.st = ST_RUN;
            end
            default: ;
        endcase

        if (act && word_end) begin
            ctl_d.left = ctl_q.left - 1'b1;
            if (last) begin
                ctl_d.st   = ST_IDLE;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, start: '0, left: '0, mode: XM_READ, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy     = (ctl_q.st != ST_IDLE);
    assign done     = ctl_q.done;
    assign mode     = ctl_q.mode;
    assign load_acc = accept && (xmode_e'(req_mode) == XM_SUM);

    a_r7_act_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> busy);

    a_r3_start_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> (bit_pos == '0) && (word_pos == ctl_q.start));

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));

    a_r10_busy_holds_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> $stable(ctl_q.start));

    a_r9_reject_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && (req_count == '0 || req_count > CW'(MAX_COUNT))) |=> !busy);

endmodule

// File: rtl/rsl_serial_acc.sv
module rsl_serial_acc #(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [WORD_BITS-1:0] seed,
    input  logic                 add_en,
    input  logic                 in_bit,
    input  logic                 word_end,
    output logic [WORD_BITS-1:0] sum
);
    typedef struct packed {
        logic [WORD_BITS-1:0] acc;
        logic                 carry;
    } acc_s;

    acc_s acc_d, acc_q;
    logic s_bit, c_out;

    always_comb begin
        acc_d = acc_q;
        s_bit = acc_q.acc[0] ^ in_bit ^ acc_q.carry;
        c_out = (acc_q.acc[0] & in_bit) | (acc_q.acc[0] & acc_q.carry) | (in_bit & acc_q.carry);
        if (load) begin
            acc_d.acc   = seed;
            acc_d.carry = 1'b0;
        end else if (add_en) begin
            acc_d.acc   = {s_bit, acc_q.acc[WORD_BITS-1:1]};
            acc_d.carry = word_end ? 1'b0 : c_out;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign sum = acc_q.acc;

    a_r11_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !add_en) |=> $stable(sum));

    a_r8_seed_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sum == $past(seed)));

endmodule

// File: rtl/rsl_word_store.sv
module rsl_word_store
    import rsl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [1:0]  req_mode,
    input  logic [4:0]  req_start,
    input  logic [5:0]  req_count,
    input  logic [31:0] acc_seed,
    input  logic        wr_bit,
    output logic        busy,
    output logic        done,
    output logic        xfer_act,
    output logic        xfer_bit,
    output logic [4:0]  word_pos,
    output logic [4:0]  bit_pos,
    output logic [31:0] acc_sum
);
    localparam int WORD_BITS = 32;
    localparam int WORDS     = 32;

    xmode_e mode;
    logic   word_end, load_acc, wr_en, add_en;

    assign wr_en  = xfer_act && (mode == XM_WRITE);
    assign add_en = xfer_act && (mode == XM_SUM);

    rsl_line #(.WORD_BITS(WORD_BITS), .WORDS(WORDS)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bit   (wr_bit),
        .out_bit  (xfer_bit),
        .bit_pos  (bit_pos),
        .word_pos (word_pos),
        .word_end (word_end)
    );

    rsl_ctrl #(.WORD_BITS(WORD_BITS), .WORDS(WORDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_mode  (req_mode),
        .req_start (req_start),
        .req_count (req_count),
        .bit_pos   (bit_pos),
        .word_pos  (word_pos),
        .word_end  (word_end),
        .busy      (busy),
        .done      (done),
        .act       (xfer_act),
        .mode      (mode),
        .load_acc  (load_acc)
    );

    rsl_serial_acc #(.WORD_BITS(WORD_BITS)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_acc),
        .seed     (acc_seed),
        .add_en   (add_en),
        .in_bit   (xfer_bit),
        .word_end (word_end),
        .sum      (acc_sum)
    );

    a_r11_read_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_act && (mode == XM_READ || mode == XM_READ_ALT)) |-> !wr_en && !add_en);

endmodule

// File: tb/rsl_word_store_tb.sv
module rsl_word_store_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [4:0]  req_start = '0;
    logic [5:0]  req_count = '0;
    logic [31:0] acc_seed = '0;
    logic        wr_bit = 1'b0;
    logic        busy, done, xfer_act, xfer_bit;
    logic [4:0]  word_pos, bit_pos;
    logic [31:0] acc_sum;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_mem [32];
    int          m_w = 0, m_b = 0, m_st = 0, m_start = 0, m_left = 0, m_mode = 0;
    logic [31:0] m_acc = '0;
    logic        m_done = 1'b0;
    logic [31:0] wr_seed = 32'h1234_5678;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rsl_word_store u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_mode(req_mode),
        .req_start(req_start), .req_count(req_count), .acc_seed(acc_seed),
        .wr_bit(wr_bit), .busy(busy), .done(done), .xfer_act(xfer_act),
        .xfer_bit(xfer_bit), .word_pos(word_pos), .bit_pos(bit_pos),
        .acc_sum(acc_sum)
    );

    function automatic logic [31:0] pat_word(logic [31:0] sd, int w);
        return sd ^ (32'(w) * 32'h9E37_79B1);
    endfunction

    function automatic logic [31:0] pat_total(logic [31:0] sd);
        logic [31:0] t = '0;
        for (int w = 0; w < 32; w++) t += pat_word(sd, w);
        return t;
    endfunction

    function automatic logic exp_act();
        return (m_st == 2) || (m_st == 1 && m_w == m_start && m_b == 0);
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] actv, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < 32; w++) m_mem[w] = '0;
            m_w = 0; m_b = 0; m_st = 0; m_left = 0; m_acc = '0; m_done = 1'b0;
        end else begin
            logic a, last;
            a    = exp_act();
            last = a && m_b == 31 && m_left == 1;
            m_done = last;
            if (a && m_mode == 1) m_mem[m_w][m_b] = wr_bit;
            if (a && m_mode == 2 && m_b == 31) m_acc += m_mem[m_w];
            if (a && m_b == 31) m_left--;
            if (m_st == 1 && a) m_st = 2;
            if (last) m_st = 0;
            else if (m_st == 0 && req && req_count >= 1 && req_count <= 33) begin
                m_st = 1; m_start = int'(req_start); m_left = int'(req_count); m_mode = int'(req_mode);
                if (req_mode == 2'd2) m_acc = acc_seed;
            end
            m_b = (m_b + 1) % 32;
            if (m_b == 0) m_w = (m_w + 1) % 32;
        end
    end

    always @(negedge clk) begin
        wr_bit <= pat_word(wr_seed, m_w)[m_b];
        if (rst_n) begin
            check(busy == (m_st != 0), "R7 busy", 32'(busy), 32'(m_st != 0));
            check(done == m_done, "R7 done", 32'(done), 32'(m_done));
            check(xfer_act == exp_act(), "R3 xfer_act", 32'(xfer_act), 32'(exp_act()));
            check(xfer_bit == m_mem[m_w][m_b], "R4/R5/R6 xfer_bit", 32'(xfer_bit), 32'(m_mem[m_w][m_b]));
            check(bit_pos == 5'(m_b) && word_pos == 5'(m_w), "R2 position",
                  {22'd0, word_pos, bit_pos}, 32'((m_w << 5) | m_b));
            if (m_st == 0) check(acc_sum == m_acc, "R8/R11 acc_sum", acc_sum, m_acc);
        end
    end

    task automatic issue(input int mode, input int start, input int count, input logic [31:0] seed);
        @(negedge clk);
        req = 1'b1; req_mode = 2'(mode); req_start = 5'(start); req_count = 6'(count); acc_seed = seed;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R7 watchdog actual=busy expected=idle");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        int cnt;
        repeat (3) @(negedge clk);
        check(!busy && !done && bit_pos == 0 && word_pos == 0 && acc_sum == 0 && !xfer_bit,
              "R1 reset state", {busy, done, 30'(acc_sum)}, 32'd0);
        rst_n = 1'b1;

        // R5: fill whole line
        wr_seed = 32'hA5C3_0F1E;
        issue(1, 0, 32, '0); wait_idle();

        // R11: read across the wrap point
        held = acc_sum;
        issue(0, 30, 4, 32'hDEAD_BEEF); wait_idle();
        check(acc_sum == held, "R11 read keeps acc", acc_sum, held);
        issue(3, 1, 2, 32'h1); wait_idle();
        check(acc_sum == held, "R11 alt read keeps acc", acc_sum, held);

        // R8: sum whole line from an offset start
        issue(2, 7, 32, 32'd123); wait_idle();
        check(acc_sum == 32'd123 + pat_total(32'hA5C3_0F1E), "R8 sum of line",
              acc_sum, 32'd123 + pat_total(32'hA5C3_0F1E));

        // R9: 33-word write revisits start
        wr_seed = 32'h3C96_71E2;
        issue(1, 9, 33, '0); wait_idle();
        issue(2, 0, 32, 32'd0); wait_idle();
        check(acc_sum == pat_total(32'h3C96_71E2), "R9 33-word write", acc_sum, pat_total(32'h3C96_71E2));
        issue(2, 3, 33, 32'd5); wait_idle();
        check(acc_sum == 32'd5 + pat_total(32'h3C96_71E2) + pat_word(32'h3C96_71E2, 3), "R9 33-word sum",
              acc_sum, 32'd5 + pat_total(32'h3C96_71E2) + pat_word(32'h3C96_71E2, 3));

        // R9: illegal counts ignored
        issue(1, 0, 0, '0);
        check(!busy, "R9 count 0 ignored", 32'(busy), 32'd0);
        issue(2, 0, 34, 32'hFFFF);
        check(!busy, "R9 count 34 ignored", 32'(busy), 32'd0);

        // R10: request while busy ignored
        issue(0, 4, 2, '0);
        wr_seed = 32'h0BAD_F00D;
        issue(1, 0, 33, '0);
        wait_idle();
        repeat (2) @(negedge clk);
        check(!busy, "R10 no extra transfer", 32'(busy), 32'd0);
        issue(2, 0, 32, 32'd0); wait_idle();
        check(acc_sum == pat_total(32'h3C96_71E2), "R10 contents kept", acc_sum, pat_total(32'h3C96_71E2));

        // R3: request in the start word's own bit-0 cycle waits a revolution
        while (!(m_w == 6 && m_b == 0)) @(negedge clk);
        req = 1'b1; req_mode = 2'd0; req_start = 5'd6; req_count = 6'd1;
        @(negedge clk);
        req = 1'b0;
        cnt = 1;
        while (!xfer_act) begin @(negedge clk); cnt++; end
        check(cnt == 1024, "R3 full revolution wait", 32'(cnt), 32'd1024);
        wait_idle();

        finish_run();
    end
endmodule